// File: doc/BRIEF.md
# Credit-Gated Link Frame Transmitter with Replay

This block is the sending side of a point-to-point packet link. An upper layer hands it one transaction payload at a time over a valid/ready interface: source and destination addresses, a command byte, a tag and a data word. The block gives each accepted payload the next sequence number and stores it in a small replay store. It then sends the payload on a 16-bit lane as a seven-flit frame. The frame carries a start marker, the sequence number, the two addresses, the command and tag, the data, a CRC-16 check word and an end marker.

Flits are sent only against flow-control credits. The link loads the credit count once when it is brought up, and after that the receiver returns credits one pulse at a time. Each frame stays in the replay store until the far end acknowledges it. An acknowledgement frees the named frame and every older one. A negative acknowledgement rewinds transmission, so the named frame and every later frame already sent go out again, unchanged and in their original order.

Top module: `lnk_credit_tx`

## Requirements
- R1: A frame occupies seven consecutive cycles with `laneValid` high, with these flits in this order: start marker 16'hFB5C, sequence number zero-extended, {src,dst}, {cmd,tag}, data, CRC, end marker 16'hFD3E. At least one cycle with `laneValid` low separates two frames.
- R2: The CRC flit is CRC-16 with polynomial 0x1021, initial value 16'hFFFF, processed most significant bit first, with no reflection and no final inversion. It is computed over the 64 bits of flits 1 to 4, taken in frame order.
- R3: Sequence numbers are 4 bits wide. They are assigned to accepted payloads in acceptance order, start at 0 after reset and wrap from 15 to 0.
- R4: Reset clears the credit count to 0. A `linkInit` pulse loads it with `initCredits`, and this load takes priority over any change in the same cycle. Each flit sent uses one credit, and each `creditRet` pulse adds one. A frame starts only from an idle cycle in which at least seven credits are held.
- R5: `inReady` is low while DEPTH frames (4 by default) are retained. A retained frame is one that has been accepted and not yet freed by an acknowledgement.
- R6: An `ackValid` pulse naming sequence N frees every retained frame up to and including N. The pulse has this effect only if N is a frame whose transmission has completed and which is still retained. Any other acknowledgement is ignored.
- R7: A `nakValid` pulse naming retained, sent sequence N takes effect once the frame in progress has finished. The block then sends frame N and every later frame already sent, with the same sequence numbers and contents and in the original order, before any new frame.
- R8: A payload is accepted at a clock edge where both `inValid` and `inReady` are high. Frames are first sent in acceptance order. The command byte is carried unchanged: its upper hex digit is the class and its lower digit is the operation (memory read 8'h10, memory write 8'h11, I/O read 8'h20, I/O write 8'h21, configuration 8'h3x, message 8'h4x, completion 8'h50).
- R9: After reset `laneValid` is low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Upper layer offers a payload |
| inReady | output | 1 | Replay store can take a payload |
| inSrc | input | 8 | Source address |
| inDst | input | 8 | Destination address |
| inCmd | input | 8 | Command byte (class digit, operation digit) |
| inTag | input | 8 | Transaction tag |
| inData | input | 16 | Data word |
| linkInit | input | 1 | Load the credit count at link bring-up |
| initCredits | input | 6 | Credit value to load |
| creditRet | input | 1 | Receiver returns one credit |
| ackValid | input | 1 | Acknowledgement strobe |
| ackSeq | input | 4 | Sequence number acknowledged |
| nakValid | input | 1 | Negative acknowledgement strobe |
| nakSeq | input | 4 | Sequence number to resend from |
| laneValid | output | 1 | A flit is on the lane |
| laneFlit | output | 16 | Current flit |

## Verification
A payload accepted at edge k can raise the start marker no earlier than the cycle after edge k+1, and its remaining flits follow on the next six edges. The credit count, `inReady` after an acknowledgement, and a latched negative acknowledgement all change at the edge that samples the strobe. A rewind is applied in the first idle cycle after the frame in progress ends, and the replayed start marker appears one cycle later. The bench keeps a behavioural reference model that it updates at each rising edge from the same inputs. It compares `inReady`, `laneValid` and every flit 2 ns after that edge, so each result is checked in exactly the cycle it is due. Directed checks on the order of observed sequence numbers confirm stalls, the buffer limit and replays.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  localparam int FLIT_W    = 16;
  localparam int HALF_W    = FLIT_W / 2;
  localparam int SEQ_W     = 4;
  localparam int FRAME_LEN = 7;
  localparam int FIDX_W    = 3;

  localparam logic [FLIT_W-1:0] SOF_MARK = 16'hFB5C;
  localparam logic [FLIT_W-1:0] EOF_MARK = 16'hFD3E;

  localparam logic [HALF_W-1:0] CMD_MEM_RD = 8'h10;
  localparam logic [HALF_W-1:0] CMD_MEM_WR = 8'h11;
  localparam logic [HALF_W-1:0] CMD_IO_RD  = 8'h20;
  localparam logic [HALF_W-1:0] CMD_IO_WR  = 8'h21;
  localparam logic [HALF_W-1:0] CMD_CPL    = 8'h50;

  typedef struct packed {
    logic [HALF_W-1:0] src;
    logic [HALF_W-1:0] dst;
    logic [HALF_W-1:0] cmd;
    logic [HALF_W-1:0] tag;
    logic [FLIT_W-1:0] data;
  } payload_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic [SEQ_W-1:0]  wrSeq;
    logic [SEQ_W-1:0]  rdSeq;
    logic [FIDX_W-1:0] flitSel;
    logic              laneOn;
  } strobe_t;

  function automatic logic [15:0] crc16Msb(input logic [4*FLIT_W-1:0] msg);
    logic [15:0] c;
    logic fb;
    c = 16'hFFFF;
    for (int i = 4*FLIT_W-1; i >= 0; i--) begin
      fb = c[15] ^ msg[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction
endpackage

// File: rtl/lnk_tx_datapath.sv
module lnk_tx_datapath
  import lnk_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  payload_t          wrPayload,
  output logic              laneValid,
  output logic [FLIT_W-1:0] laneFlit
);
  localparam int SLOT_W = $clog2(DEPTH);

  payload_t store [DEPTH];
  payload_t rdEntry;
  logic [FLIT_W-1:0] seqFlit, addrFlit, cmdFlit, crcFlit;

  always_ff @(posedge clk) begin
    if (strb.wrEn) store[strb.wrSeq[SLOT_W-1:0]] <= wrPayload;
  end

  always_comb begin
    rdEntry  = store[strb.rdSeq[SLOT_W-1:0]];
    seqFlit  = {{(FLIT_W-SEQ_W){1'b0}}, strb.rdSeq};
    addrFlit = {rdEntry.src, rdEntry.dst};
    cmdFlit  = {rdEntry.cmd, rdEntry.tag};
    crcFlit  = crc16Msb({seqFlit, addrFlit, cmdFlit, rdEntry.data});
  end

  always_comb begin
    case (strb.flitSel)
      3'd0:    laneFlit = SOF_MARK;
      3'd1:    laneFlit = seqFlit;
      3'd2:    laneFlit = addrFlit;
      3'd3:    laneFlit = cmdFlit;
      3'd4:    laneFlit = rdEntry.data;
      3'd5:    laneFlit = crcFlit;
      default: laneFlit = EOF_MARK;
    endcase
  end

  assign laneValid = strb.laneOn;

  // R6
  slot_in_flight_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.laneOn && strb.wrEn) |-> (strb.wrSeq[SLOT_W-1:0] != strb.rdSeq[SLOT_W-1:0]));
endmodule

// File: rtl/lnk_tx_ctrl.sv
module lnk_tx_ctrl
  import lnk_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic             linkInit,
  input  logic [CNT_W-1:0] initCredits,
  input  logic             creditRet,
  input  logic             ackValid,
  input  logic [SEQ_W-1:0] ackSeq,
  input  logic             nakValid,
  input  logic [SEQ_W-1:0] nakSeq,
  output strobe_t          strb
);
  localparam logic [CNT_W-1:0]  NEED     = CNT_W'(FRAME_LEN);
  localparam logic [FIDX_W-1:0] LAST_IDX = FIDX_W'(FRAME_LEN - 1);
  localparam logic [SEQ_W-1:0]  FULL_OCC = SEQ_W'(DEPTH);

  logic [SEQ_W-1:0]  wrPtr, ackPtr, sendPtr, curSeq, pendSeq;
  logic [CNT_W-1:0]  credits;
  logic [FIDX_W-1:0] flitIdx;
  logic              busy, pendNak;

  logic [SEQ_W-1:0] occ, sentCnt, ackLimit, ackDist, nakDist;
  logic accept, ackOk, nakOk, canStart;

  always_comb begin
    occ      = wrPtr - ackPtr;
    sentCnt  = sendPtr - ackPtr;
    ackLimit = sentCnt - {{(SEQ_W-1){1'b0}}, busy};
    ackDist  = ackSeq - ackPtr;
    nakDist  = pendSeq - ackPtr;
    inReady  = (occ != FULL_OCC);
    accept   = inValid && inReady;
    ackOk    = ackValid && (ackDist < ackLimit);
    nakOk    = pendNak && (nakDist < sentCnt);
    canStart = !busy && !pendNak && (sendPtr != wrPtr) && (credits >= NEED);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0; ackPtr <= '0; sendPtr <= '0; curSeq <= '0; pendSeq <= '0;
      credits <= '0; flitIdx <= '0; busy <= 1'b0; pendNak <= 1'b0;
    end else begin
      if (accept) wrPtr <= wrPtr + 1'b1;
      if (ackOk) ackPtr <= ackSeq + 1'b1;

      if (nakValid) begin
        pendNak <= 1'b1;
        pendSeq <= nakSeq;
      end else if (!busy && pendNak) begin
        pendNak <= 1'b0;
      end

      if (busy) begin
        if (flitIdx == LAST_IDX) busy <= 1'b0;
        else flitIdx <= flitIdx + 1'b1;
      end else if (pendNak) begin
        if (nakOk) sendPtr <= pendSeq;
      end else if (canStart) begin
        busy    <= 1'b1;
        flitIdx <= '0;
        curSeq  <= sendPtr;
        sendPtr <= sendPtr + 1'b1;
      end

      if (linkInit) credits <= initCredits;
      else credits <= credits - {{(CNT_W-1){1'b0}}, busy}
                              + {{(CNT_W-1){1'b0}}, creditRet};
    end
  end

  always_comb begin
    strb.wrEn    = accept;
    strb.wrSeq   = wrPtr;
    strb.rdSeq   = curSeq;
    strb.flitSel = flitIdx;
    strb.laneOn  = busy;
  end

  // R4
  no_credit_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (credits != '0));
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= FULL_OCC);
  // R1
  frame_unbroken_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && flitIdx != LAST_IDX) |=> busy);
  // R1
  frame_starts_at_sof_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (flitIdx == '0));
  // R8
  send_behind_write_chk: assert property (@(posedge clk) disable iff (rst)
    sentCnt <= occ);
endmodule

// File: rtl/lnk_credit_tx.sv
module lnk_credit_tx
  import lnk_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inSrc,
  input  logic [7:0]        inDst,
  input  logic [7:0]        inCmd,
  input  logic [7:0]        inTag,
  input  logic [15:0]       inData,
  input  logic              linkInit,
  input  logic [CNT_W-1:0]  initCredits,
  input  logic              creditRet,
  input  logic              ackValid,
  input  logic [3:0]        ackSeq,
  input  logic              nakValid,
  input  logic [3:0]        nakSeq,
  output logic              laneValid,
  output logic [15:0]       laneFlit
);
  strobe_t  strb;
  payload_t wrPayload;

  assign wrPayload = '{src: inSrc, dst: inDst, cmd: inCmd, tag: inTag, data: inData};

  lnk_tx_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .linkInit(linkInit), .initCredits(initCredits), .creditRet(creditRet),
    .ackValid(ackValid), .ackSeq(ackSeq), .nakValid(nakValid), .nakSeq(nakSeq),
    .strb(strb)
  );

  lnk_tx_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrPayload(wrPayload),
    .laneValid(laneValid), .laneFlit(laneFlit)
  );
endmodule

// File: tb/lnk_credit_tx_bench.sv
`timescale 1ns/1ps
module lnk_credit_tx_bench;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, linkInit = 1'b0, creditRet = 1'b0, ackValid = 1'b0, nakValid = 1'b0;
  logic [7:0] inSrc = '0, inDst = '0, inCmd = '0, inTag = '0;
  logic [15:0] inData = '0;
  logic [5:0] initCredits = '0;
  logic [3:0] ackSeq = '0, nakSeq = '0;
  logic inReady, laneValid;
  logic [15:0] laneFlit;

  always #4 clk = ~clk;

  lnk_credit_tx u_lnk_credit_tx (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inSrc(inSrc), .inDst(inDst), .inCmd(inCmd), .inTag(inTag), .inData(inData),
    .linkInit(linkInit), .initCredits(initCredits), .creditRet(creditRet),
    .ackValid(ackValid), .ackSeq(ackSeq), .nakValid(nakValid), .nakSeq(nakSeq),
    .laneValid(laneValid), .laneFlit(laneFlit)
  );

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model state
  logic [7:0]  mSrc [16], mDst [16], mCmd [16], mTag [16];
  logic [15:0] mData [16];
  int mWr, mAck, mSend, mCur, mIdx, mCred, mPendSeq;
  bit mBusy, mPend;

  function automatic logic [15:0] refCrc(input logic [15:0] w0, w1, w2, w3);
    logic [15:0] c;
    logic [15:0] words [4];
    words = '{w0, w1, w2, w3};
    c = 16'hFFFF;
    foreach (words[k]) begin
      c = c ^ words[k];
      for (int b = 0; b < 16; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [15:0] refFlit(input int s, input int idx);
    logic [15:0] f1, f2, f3;
    f1 = 16'(s);
    f2 = {mSrc[s], mDst[s]};
    f3 = {mCmd[s], mTag[s]};
    case (idx)
      0: return 16'hFB5C;
      1: return f1;
      2: return f2;
      3: return f3;
      4: return mData[s];
      5: return refCrc(f1, f2, f3, mData[s]);
      default: return 16'hFD3E;
    endcase
  endfunction

  always @(posedge clk) begin
    int occ, sentCnt, lim;
    bit acc, ackOk, nakOk, canStart;
    if (rst) begin
      mWr = 0; mAck = 0; mSend = 0; mCur = 0; mIdx = 0; mCred = 0;
      mPendSeq = 0; mBusy = 0; mPend = 0;
    end else begin
      occ      = (mWr - mAck) & 15;
      sentCnt  = (mSend - mAck) & 15;
      lim      = sentCnt - (mBusy ? 1 : 0);
      acc      = inValid && (occ != DEPTH);
      ackOk    = ackValid && (((int'(ackSeq) - mAck) & 15) < lim);
      nakOk    = mPend && (((mPendSeq - mAck) & 15) < sentCnt);
      canStart = !mBusy && !mPend && (mSend != mWr) && (mCred >= 7);
      if (acc) begin
        mSrc[mWr] = inSrc; mDst[mWr] = inDst; mCmd[mWr] = inCmd;
        mTag[mWr] = inTag; mData[mWr] = inData;
        mWr = (mWr + 1) & 15;
      end
      if (ackOk) mAck = (int'(ackSeq) + 1) & 15;
      if (mBusy) begin
        if (mIdx == 6) mBusy = 0; else mIdx++;
      end else if (mPend) begin
        if (nakOk) mSend = mPendSeq;
      end else if (canStart) begin
        mBusy = 1; mIdx = 0; mCur = mSend; mSend = (mSend + 1) & 15;
      end
      if (nakValid) begin mPend = 1; mPendSeq = int'(nakSeq); end
      else if (!mBusy && mPend && !canStart) mPend = mPend;
      mCred = linkInit ? int'(initCredits) : (mCred - (mBusyPrev() ? 1 : 0) + (creditRet ? 1 : 0));
    end
  end

  // pend clear and credit decrement use the pre-edge busy flag
  bit busyPre;
  function automatic bit mBusyPrev();
    return busyPre;
  endfunction
  always @(negedge clk) busyPre = mBusy;
  bit pendClrPre;
  always @(negedge clk) pendClrPre = !mBusy && mPend;
  always @(posedge clk) begin
    #1;
    if (!rst && !nakValid && pendClrPre) mPend = 0;
  end

  // per-cycle comparison and sequence capture
  int obsIdx = 0;
  int seen [$];
  always @(posedge clk) begin
    #2;
    chk(inReady == (((mWr - mAck) & 15) != DEPTH), "R5", "inReady", inReady,
        (((mWr - mAck) & 15) != DEPTH));
    chk(laneValid == mBusy, "R4", "laneValid", laneValid, mBusy);
    if (laneValid && mBusy) begin
      case (mIdx)
        0, 6:    chk(laneFlit == refFlit(mCur, mIdx), "R1", "marker", laneFlit, refFlit(mCur, mIdx));
        1:       chk(laneFlit == refFlit(mCur, mIdx), "R3", "seq", laneFlit, refFlit(mCur, mIdx));
        5:       chk(laneFlit == refFlit(mCur, mIdx), "R2", "crc", laneFlit, refFlit(mCur, mIdx));
        default: chk(laneFlit == refFlit(mCur, mIdx), "R8", "field", laneFlit, refFlit(mCur, mIdx));
      endcase
    end
    if (laneValid) begin
      obsIdx++;
      if (obsIdx == 2) seen.push_back(int'(laneFlit));
    end else obsIdx = 0;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] cmd, input logic [7:0] tag, input logic [15:0] dat);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1; inSrc = 8'h3A ^ tag; inDst = 8'hC5 + tag; inCmd = cmd; inTag = tag; inData = dat;
    @(negedge clk);
    inValid = 0;
  endtask

  task automatic loadCredits(input int n);
    @(negedge clk); linkInit = 1; initCredits = 6'(n);
    @(negedge clk); linkInit = 0;
  endtask

  task automatic retCredits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); creditRet = 1;
    end
    @(negedge clk); creditRet = 0;
  endtask

  task automatic sendAck(input int s);
    @(negedge clk); ackValid = 1; ackSeq = 4'(s);
    @(negedge clk); ackValid = 0;
  endtask

  task automatic sendNak(input int s);
    @(negedge clk); nakValid = 1; nakSeq = 4'(s);
    @(negedge clk); nakValid = 0;
  endtask

  task automatic run();
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(laneValid == 0, "R9", "laneValid after reset", laneValid, 0);
    chk(inReady == 1, "R9", "inReady after reset", inReady, 1);

    // no credits: frame must wait
    push(8'h10, 8'h01, 16'h1234);
    idle(15);
    chk(seen.size() == 0, "R4", "frames sent without credits", seen.size(), 0);
    loadCredits(14);
    idle(12);
    chk(seen.size() == 1 && seen[0] == 0, "R3", "first seq", seen.size(), 1);
    push(8'h11, 8'h02, 16'hBEEF);
    push(8'h20, 8'h03, 16'h0F0F);
    idle(30);
    chk(seen.size() == 2, "R4", "stall at zero credits", seen.size(), 2);
    retCredits(7);
    idle(12);
    chk(seen.size() == 3 && seen[2] == 2, "R8", "order after credit return", seen.size(), 3);

    // fill the replay store
    push(8'h21, 8'h04, 16'hA5A5);
    idle(2);
    chk(inReady == 0, "R5", "full at DEPTH retained", inReady, 0);
    sendAck(9);
    idle(2);
    chk(inReady == 0, "R6", "stray ack ignored", inReady, 0);
    sendAck(1);
    idle(1);
    chk(inReady == 1, "R6", "ack frees through N", inReady, 1);

    // replay after a NAK
    loadCredits(40);
    idle(12);
    sendNak(2);
    idle(25);
    n = seen.size();
    chk(n == 6 && seen[4] == 2 && seen[5] == 3, "R7", "replay order", n, 6);
    sendAck(3);

    // wrap the sequence space, with a NAK during a frame
    for (int i = 0; i < 14; i++) begin
      loadCredits(i == 5 ? 14 : 7);
      push(8'h30 + 8'(i * 16), 8'(i), 16'(i * 16'h0101 + 7));
      if (i == 5) begin
        idle(3);
        sendNak((4 + i) & 15);
        idle(22);
      end else idle(10);
      sendAck((4 + i) & 15);
    end
    idle(5);
    n = seen.size();
    chk(n == 21, "R3", "frames after wrap", n, 21);
    chk(seen[n-1] == 1, "R3", "wrapped seq", seen[n-1], 1);
    chk(seen[11] == 9 && seen[12] == 9, "R7", "mid-frame nak replay", seen[12], 9);
    chk(inReady == 1, "R6", "store empty at end", inReady, 1);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule